// File: doc/BRIEF.md
# HDLC Receive Deframer

This block recovers HDLC frames from a stream of octets sampled off one B channel. Each octet is read least significant bit first. In 64k mode all eight bits carry line data. In 56k mode only bits 0 to 6 carry data and bit 7 is ignored. Internally a four-state search walks the bits one at a time. The states are: idle hunt for a zero, hunt for a flag, synchronised on a flag, and inside a frame. Along the way the block discards stuffed zeros, assembles data octets and runs the CRC-16 frame check over them.

Recovered bytes leave the block as a stream, one byte per output strobe. The block holds back the three most recently assembled bytes, so the two frame-check bytes are never presented as payload. The final payload byte carries an end tag and a verdict: good or bad. Any frame that is cut short also ends with a bad-tagged byte, so a consumer can drop what it has gathered. Three wrapping counters record alignment errors, FCS errors and oversize frames.

Top module: `hdlc_deframer`

## Requirements
- R1: After reset the block is hunting for a zero bit, `out_valid` is low and all three error counters read zero.
- R2: In 64k mode (`mode_56k`=0) all eight bits of an octet are used, bit 0 first. A frame is delimited by flags (bits 0,1,1,1,1,1,1,0). Its payload bytes come out in order, with `out_last`=1 and `out_good`=1 on the final one. The two trailing FCS bytes never appear on `out_byte`.
- R3: In 56k mode (`mode_56k`=1) only bits 0 to 6 of each octet are used, and bit 7 has no effect on the output.
- R4: An octet whose used bits are all ones (0xFF in 64k mode; 0x7F under mask in 56k mode) returns the block to the zero hunt and clears its bit and ones counts. A frame in progress is ended by emitting its pending byte with `out_last`=1 and `out_good`=0.
- R5: A zero that follows exactly five ones inside a frame is removed and is not counted as data.
- R6: Seven or more consecutive ones abort the current frame. The block returns to the zero hunt, and a frame in progress ends with a bad-tagged byte. No counter changes.
- R7: A single flag can both close one frame and open the next. Repeated flags between frames are allowed.
- R8: A closing flag that arrives when the bit count is not a multiple of 8 increments `align_errs`. The frame ends with a bad tag, and the block goes back to hunting for a flag.
- R9: At an aligned closing flag, the CRC-16 (reflected polynomial 0x8408, preset 0xFFFF) computed over all received bytes must equal the residue 0xF0B8. If it does not, or if fewer than three bytes were received, `fcs_errs` increments and the frame ends with a bad tag; a frame of fewer than three bytes produces no output at all.
- R10: When a completed byte would bring the frame's byte count to `MAX_BYTES`, that byte is not stored. `size_errs` increments, the frame ends with a bad tag, and the block hunts for a flag.
- R11: Outputs are registered, so a byte appears the cycle after the octet that released it. A byte is released when the third byte after it completes. If a frame is cut off in the same octet in which a byte is released, that released byte takes the bad end tag.
- R12: Each error counter steps by exactly one per error. Good frames, aborts and idle octets leave all counters unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_56k | input | 1 | 1 = 7 data bits per octet, 0 = 8 |
| in_valid | input | 1 | Octet present on `in_octet` this cycle |
| in_octet | input | 8 | Line octet, bit 0 received first |
| out_valid | output | 1 | Payload byte strobe |
| out_byte | output | 8 | Payload byte |
| out_last | output | 1 | Final byte of a frame |
| out_good | output | 1 | With `out_last`: frame passed its check |
| align_errs | output | CNT_W | Count of non-aligned closing flags |
| fcs_errs | output | CNT_W | Count of FCS mismatches and runt frames |
| size_errs | output | CNT_W | Count of oversize frames |

## Verification
Within one octet, a byte can be released onto the output and the frame can also be cut off by an abort. The bench sets this up with a run of four leading ones, which shifts byte boundaries to bit 3 of each octet. The last data byte is 0xE0, and four raw ones follow it, so the seventh consecutive one falls in the same octet as that byte's completion. The expected stream, computed in the bench, ends one byte earlier than in a non-coincident abort, with the bad tag on the byte released in that octet. A misaligned closing flag can also coincide with a byte completing from flag bits; there the bench judges only that exactly one bad end tag appears and that `align_errs` advances.

// File: rtl/hdlc_deframer.sv
`timescale 1ns/1ps
module hdlc_deframer #(
  parameter int MAX_BYTES = 4096,
  parameter int CNT_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_56k,
  input  logic             in_valid,
  input  logic [7:0]       in_octet,
  output logic             out_valid,
  output logic [7:0]       out_byte,
  output logic             out_last,
  output logic             out_good,
  output logic [CNT_W-1:0] align_errs,
  output logic [CNT_W-1:0] fcs_errs,
  output logic [CNT_W-1:0] size_errs
);
  localparam int BCW = $clog2(MAX_BYTES) + 4;
  localparam logic [BCW-1:0] MAXB = BCW'(MAX_BYTES);

  typedef enum logic [1:0] {S_ZERO, S_HUNT, S_SYNC, S_DATA} st_t;

  st_t             st_q, s;
  logic [2:0]      ones_q, on;
  logic [7:0]      rv_q, rv;
  logic [BCW-1:0]  bc_q, bc;
  logic [15:0]     fcs_q, fc;
  logic [2:0][7:0] hold_q, hd;
  logic [1:0]      nh_q, nh;
  logic [7:0]      mask;
  logic            b, chk, term, good, ev, el, eg, inc_a, inc_f, inc_s;
  logic [7:0]      eb;

  assign mask = mode_56k ? 8'h7F : 8'hFF;

  function automatic logic [15:0] crc_upd(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++)
      r = (r[0] ^ d[i]) ? ((r >> 1) ^ 16'h8408) : (r >> 1);
    return r;
  endfunction

  always_comb begin
    s = st_q; on = ones_q; rv = rv_q; bc = bc_q; fc = fcs_q; hd = hold_q; nh = nh_q;
    b = 1'b0; chk = 1'b0; term = 1'b0; good = 1'b0;
    ev = 1'b0; eb = 8'h00; el = 1'b0; eg = 1'b0;
    inc_a = 1'b0; inc_f = 1'b0; inc_s = 1'b0;
    if (in_valid) begin
      if ((in_octet & mask) == mask) begin
        if (s == S_DATA) term = 1'b1;
        s = S_ZERO; bc = '0; on = 3'd0;
      end else begin
        for (int j = 0; j < 8; j++) begin
          if (j < 7 || !mode_56k) begin
            b = in_octet[j];
            chk = 1'b1;
            case (s)
              S_ZERO: begin
                if (b) on = (on == 3'd7) ? 3'd7 : on + 3'd1;
                else begin on = 3'd0; s = S_HUNT; end
              end
              S_HUNT: begin
                if (b) begin
                  on = (on == 3'd7) ? 3'd7 : on + 3'd1;
                  if (on == 3'd7) s = S_ZERO;
                end else begin
                  if (on == 3'd6) begin bc = '0; rv = 8'h00; s = S_SYNC; end
                  on = 3'd0;
                end
              end
              S_SYNC: begin
                if (b) begin
                  on = (on == 3'd7) ? 3'd7 : on + 3'd1;
                  if (on == 3'd7) s = S_ZERO;
                  else begin rv = {1'b1, rv[7:1]}; bc = bc + BCW'(1); end
                end else begin
                  if (on == 3'd6) begin bc = '0; rv = 8'h00; chk = 1'b0; end
                  else if (on != 3'd5) begin rv = {1'b0, rv[7:1]}; bc = bc + BCW'(1); end
                  on = 3'd0;
                end
                if (chk && s == S_SYNC && bc[2:0] == 3'd0) begin
                  s = S_DATA; fc = crc_upd(16'hFFFF, rv); hd[0] = rv; nh = 2'd1;
                end
              end
              S_DATA: begin
                if (b) begin
                  on = (on == 3'd7) ? 3'd7 : on + 3'd1;
                  if (on == 3'd7) begin s = S_ZERO; bc = '0; term = 1'b1; end
                  else begin rv = {1'b1, rv[7:1]}; bc = bc + BCW'(1); end
                end else if (on == 3'd6) begin
                  rv = 8'h00; bc = bc + BCW'(1); term = 1'b1; chk = 1'b0;
                  if (bc[2:0] != 3'd0) begin inc_a = 1'b1; s = S_HUNT; end
                  else begin
                    if (nh == 2'd3 && fc == 16'hF0B8) good = 1'b1;
                    else inc_f = 1'b1;
                    s = S_SYNC;
                  end
                  bc = '0; on = 3'd0;
                end else if (on == 3'd5) begin
                  on = 3'd0; chk = 1'b0;
                end else begin
                  rv = {1'b0, rv[7:1]}; bc = bc + BCW'(1); on = 3'd0;
                end
                if (chk && s == S_DATA && bc[2:0] == 3'd0) begin
                  if ((bc >> 3) >= MAXB) begin
                    inc_s = 1'b1; term = 1'b1; rv = 8'h00; s = S_HUNT;
                  end else begin
                    fc = crc_upd(fc, rv);
                    if (nh == 2'd3) begin ev = 1'b1; eb = hd[2]; end
                    hd = {hd[1], hd[0], rv};
                    if (nh != 2'd3) nh = nh + 2'd1;
                  end
                end
              end
              default: s = S_ZERO;
            endcase
          end
        end
      end
      if (term) begin
        if (good) begin ev = 1'b1; eb = hd[2]; el = 1'b1; eg = 1'b1; end
        else if (ev) el = 1'b1;
        else if (nh == 2'd3) begin ev = 1'b1; eb = hd[2]; el = 1'b1; end
        nh = 2'd0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_ZERO; ones_q <= 3'd0; rv_q <= 8'h00; bc_q <= '0; fcs_q <= 16'hFFFF;
      hold_q <= '0; nh_q <= 2'd0;
      out_valid <= 1'b0; out_byte <= 8'h00; out_last <= 1'b0; out_good <= 1'b0;
      align_errs <= '0; fcs_errs <= '0; size_errs <= '0;
    end else begin
      st_q <= s; ones_q <= on; rv_q <= rv; bc_q <= bc; fcs_q <= fc;
      hold_q <= hd; nh_q <= nh;
      out_valid <= ev; out_byte <= eb; out_last <= el; out_good <= eg;
      align_errs <= align_errs + CNT_W'(inc_a);
      fcs_errs   <= fcs_errs + CNT_W'(inc_f);
      size_errs  <= size_errs + CNT_W'(inc_s);
    end
  end

  // R4
  idle_octet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ((in_octet & mask) == mask)) |=> (st_q == S_ZERO && ones_q == 3'd0));
  // R11
  out_after_octet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));
  // R8
  align_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (align_errs != $past(align_errs)) |-> (align_errs == $past(align_errs) + CNT_W'(1) && $past(in_valid)));
  // R9
  fcs_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fcs_errs != $past(fcs_errs)) |-> (fcs_errs == $past(fcs_errs) + CNT_W'(1) && $past(in_valid)));
  // R10
  size_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (size_errs != $past(size_errs)) |-> (size_errs == $past(size_errs) + CNT_W'(1) && $past(in_valid)));
  // R12
  good_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_last && out_good) |-> ($stable(align_errs) && $stable(fcs_errs) && $stable(size_errs)));
endmodule

// File: tb/hdlc_deframer_test.sv
`timescale 1ns/1ps
module hdlc_deframer_test;
  localparam int MAXB = 16;
  logic clk = 1'b0, rst_n = 1'b0, mode_56k = 1'b0, in_valid = 1'b0;
  logic [7:0] in_octet = 8'h00;
  logic out_valid, out_last, out_good;
  logic [7:0] out_byte;
  logic [15:0] align_errs, fcs_errs, size_errs;

  always #2.5 clk = ~clk;

  hdlc_deframer #(.MAX_BYTES(MAXB), .CNT_W(16)) uut (
    .clk(clk), .rst_n(rst_n), .mode_56k(mode_56k), .in_valid(in_valid), .in_octet(in_octet),
    .out_valid(out_valid), .out_byte(out_byte), .out_last(out_last), .out_good(out_good),
    .align_errs(align_errs), .fcs_errs(fcs_errs), .size_errs(size_errs));

  int errors = 0, checks = 0, ea = 0, ef = 0, es = 0, run = 0;
  int unsigned sd;
  bit bs[$];
  logic [7:0] gb[$], xb[$];
  bit gl[$], gg[$], xl[$], xg[$];

  always @(negedge clk) if (rst_n && out_valid) begin
    gb.push_back(out_byte); gl.push_back(out_last); gg.push_back(out_good);
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_step(logic [15:0] c, logic [7:0] d);
    logic fb;
    for (int i = 0; i < 8; i++) begin
      fb = c[0] ^ d[i];
      c = {1'b0, c[15:1]};
      if (fb) c = c ^ 16'h8408;
    end
    return c;
  endfunction

  task automatic flag_bits();
    bs.push_back(1'b0);
    for (int i = 0; i < 6; i++) bs.push_back(1'b1);
    bs.push_back(1'b0);
    run = 0;
  endtask

  task automatic dbit(bit v);
    bs.push_back(v);
    if (v) run++; else run = 0;
    if (run == 5) begin bs.push_back(1'b0); run = 0; end
  endtask

  task automatic dbyte(logic [7:0] d);
    for (int i = 0; i < 8; i++) dbit(d[i]);
  endtask

  task automatic body(logic [7:0] p[$], bit spoil);
    logic [15:0] c;
    c = 16'hFFFF; run = 0;
    foreach (p[i]) begin c = crc_step(c, p[i]); dbyte(p[i]); end
    c = ~c;
    if (spoil) c[3] = ~c[3];
    dbyte(c[7:0]); dbyte(c[15:8]);
  endtask

  task automatic expect_bytes(logic [7:0] p[$], int n, bit good);
    for (int i = 0; i < n; i++) begin
      xb.push_back(p[i]); xl.push_back(i == n - 1); xg.push_back(good && i == n - 1);
    end
  endtask

  task automatic send_octet(logic [7:0] o);
    if ($urandom_range(3) == 0) begin in_valid = 1'b0; @(negedge clk); end
    in_valid = 1'b1; in_octet = o;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_stream();
    logic [7:0] o;
    while (bs.size() > 0) begin
      for (int i = 0; i < 8; i++) begin
        if (i < 7 || !mode_56k) o[i] = (bs.size() > 0) ? bs.pop_front() : 1'b1;
        else o[i] = 1'($urandom_range(1));
      end
      send_octet(o);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) send_octet(mode_56k ? {1'($urandom_range(1)), 7'h7F} : 8'hFF);
  endtask

  task automatic settle();
    idle(2);
    repeat (3) @(negedge clk);
  endtask

  task automatic compare(string req);
    chk(gb.size() == xb.size(), req, "byte count", gb.size(), xb.size());
    for (int i = 0; i < gb.size() && i < xb.size(); i++) begin
      chk(gb[i] == xb[i], req, "byte", gb[i], xb[i]);
      chk(gl[i] == xl[i] && gg[i] == xg[i], req, "end/good tag", {gl[i], gg[i]}, {xl[i], xg[i]});
    end
    chk(align_errs == ea, "R8", "align_errs", align_errs, ea);
    chk(fcs_errs == ef, "R9", "fcs_errs", fcs_errs, ef);
    chk(size_errs == es, "R12", "size_errs", size_errs, es);
    gb.delete(); gl.delete(); gg.delete(); xb.delete(); xl.delete(); xg.delete();
  endtask

  task automatic rand_payload(output logic [7:0] p[$], input int n, input logic [7:0] m);
    p.delete();
    for (int i = 0; i < n; i++) p.push_back(8'($urandom) & m);
  endtask

  task automatic good_frame(logic [7:0] p[$], string req);
    bs.delete(); flag_bits(); body(p, 1'b0); flag_bits();
    send_stream(); settle();
    expect_bytes(p, p.size(), 1'b1);
    compare(req);
  endtask

  initial begin
    logic [7:0] p[$], q[$];
    sd = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
    chk(align_errs == 0 && fcs_errs == 0 && size_errs == 0, "R1", "counters in reset",
        align_errs + fcs_errs + size_errs, 0);
    rst_n = 1'b1;
    @(negedge clk);
    idle(1);
    chk(gb.size() == 0, "R1", "no output on idle", gb.size(), 0);

    // R5: bytes that force zero insertion
    p = '{8'h7E, 8'hFF, 8'hFF, 8'h1F, 8'hF8, 8'h7E};
    good_frame(p, "R5");

    // R2: random 64k frames
    for (int k = 0; k < 25; k++) begin
      rand_payload(p, 1 + $urandom_range(11), 8'hFF);
      good_frame(p, "R2");
    end

    // R3: random 56k frames with random bit 7
    mode_56k = 1'b1; idle(1);
    for (int k = 0; k < 15; k++) begin
      rand_payload(p, 1 + $urandom_range(11), 8'hFF);
      good_frame(p, "R3");
    end
    mode_56k = 1'b0; idle(1);

    // R7: one flag shared between two frames, then doubled flags
    rand_payload(p, 4, 8'hFF); rand_payload(q, 3, 8'hFF);
    bs.delete(); flag_bits(); body(p, 1'b0); flag_bits(); body(q, 1'b0);
    flag_bits(); flag_bits(); body(p, 1'b0); flag_bits();
    send_stream(); settle();
    expect_bytes(p, p.size(), 1'b1); expect_bytes(q, q.size(), 1'b1); expect_bytes(p, p.size(), 1'b1);
    compare("R7");

    // R9: spoiled FCS, then a runt
    rand_payload(p, 5, 8'hFF);
    bs.delete(); flag_bits(); body(p, 1'b1); flag_bits();
    send_stream(); settle();
    ef++; expect_bytes(p, p.size(), 1'b0); compare("R9");
    p.delete();
    bs.delete(); flag_bits(); body(p, 1'b0); flag_bits();
    send_stream(); settle();
    ef++; compare("R9");

    // R8: three extra bits before the closing flag
    rand_payload(p, 6, 8'hFF);
    bs.delete(); flag_bits(); body(p, 1'b0);
    bs.push_back(1'b0); bs.push_back(1'b1); bs.push_back(1'b0);
    flag_bits(); send_stream(); settle();
    ea++;
    chk(gl.size() > 0 && gl[gl.size() - 1] == 1'b1 && gg[gg.size() - 1] == 1'b0, "R8",
        "ends with bad tag", gl.size(), 1);
    chk(gl.sum() with (int'(item)) == 1 && gg.sum() with (int'(item)) == 0, "R8",
        "single end tag, none good", gl.sum() with (int'(item)), 1);
    gb.delete(); gl.delete(); gg.delete();
    compare("R8");
    good_frame(p, "R8");

    // R6: abort not sharing an octet with a byte release
    rand_payload(p, 6, 8'h33);
    bs.delete(); flag_bits(); foreach (p[i]) dbyte(p[i]);
    for (int i = 0; i < 7; i++) bs.push_back(1'b1);
    send_stream(); settle();
    expect_bytes(p, 4, 1'b0); compare("R6");

    // R11: abort in the same octet as a byte release
    rand_payload(p, 5, 8'h33); p.push_back(8'hE0);
    bs.delete();
    for (int i = 0; i < 4; i++) bs.push_back(1'b1);
    flag_bits(); foreach (p[i]) dbyte(p[i]);
    for (int i = 0; i < 4; i++) bs.push_back(1'b1);
    send_stream(); settle();
    expect_bytes(p, 3, 1'b0); compare("R11");

    // R4: idle octet inside a frame, 64k
    rand_payload(p, 5, 8'h33);
    bs.delete(); flag_bits(); foreach (p[i]) dbyte(p[i]);
    send_stream(); send_octet(8'hFF); settle();
    expect_bytes(p, 3, 1'b0); compare("R4");
    rand_payload(p, 4, 8'hFF); good_frame(p, "R4");

    // R4: idle octet 0x7F inside a frame, 56k
    mode_56k = 1'b1; idle(1);
    rand_payload(p, 6, 8'h33);
    bs.delete(); flag_bits(); foreach (p[i]) dbyte(p[i]);
    send_stream(); send_octet(8'h7F); settle();
    expect_bytes(p, 4, 1'b0); compare("R4");
    rand_payload(p, 4, 8'hFF); good_frame(p, "R4");
    mode_56k = 1'b0; idle(1);

    // R10: largest accepted frame, then one byte more
    rand_payload(p, MAXB - 3, 8'hFF); good_frame(p, "R10");
    rand_payload(p, MAXB - 2, 8'hFF);
    bs.delete(); flag_bits(); body(p, 1'b0); flag_bits();
    send_stream(); settle();
    es++; expect_bytes(p, MAXB - 3, 1'b0);
    chk(size_errs == es, "R10", "size_errs", size_errs, es);
    compare("R10");
    rand_payload(p, 3, 8'hFF); good_frame(p, "R12");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule